// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block takes parallel stereo sample pairs and shifts them out, most significant bit first, on a three-wire serial audio link made of a bit clock, a word-select (frame) clock and a data line. Two framings are available: I2S, where the first data bit follows the word-select transition by one bit clock, and MSB-justified, where the first data bit coincides with that transition. Both framings use the same shifter.

In master operation the block derives the bit clock from the system clock by a fixed division and generates the word select itself, with a fixed number of bit slots per channel. In slave operation both clocks arrive from outside. They are synchronised into the system clock domain and the shifter is stepped on each detected falling bit-clock edge. A sample pair written through the valid strobe is held as pending and is taken up at the next frame start. If no new pair arrives, the previous pair is sent again. After reset the data line is held low for a set number of whole frames, so that a downstream receiver never sees data that has not settled.

Top module: `ats_tx`

## Requirements
- R1: In master mode (`master_i` = 1) `bclk_o` is the system clock divided by `MCLK_DIV` (default 4). It is high for the upper half of each division period and low for the lower half.
- R2: In master mode each frame is 2×`SLOTS` bit clocks long. `ws_o` is low for the `SLOTS` left-channel slots and then high for the `SLOTS` right-channel slots. It changes only when `bclk_o` falls.
- R3: In slave mode (`master_i` = 0) `bclk_o` and `ws_o` stay low. Data advances on falling edges of `bclk_i`, and every change of `ws_i` starts a new channel at slot 0. Low on `ws_i` selects left and high selects right.
- R4: With `fmt_msbj_i` = 0 (I2S) the channel word occupies slots 1 to `SAMPLE_W`, MSB first. Slot 0 and the slots after the LSB are driven low.
- R5: With `fmt_msbj_i` = 1 (MSB-justified) the channel word occupies slots 0 to `SAMPLE_W`-1, MSB first. The remaining slots are driven low.
- R6: `sdata_o` changes only on a falling bit-clock edge, so that it is stable while the bit clock is high.
- R7: A pair written with `sample_valid_i` is used from the next frame start, where a frame starts at slot 0 of the left channel. A pair written in the middle of a frame leaves the rest of that frame unchanged.
- R8: When no pair is written during a frame, the next frame repeats the pair that was last used.
- R9: The first `MUTE_FRAMES` frames after reset carry all-zero data whatever was written. Frame `MUTE_FRAMES`+1 carries the latched pair.
- R10: While reset is held, `sdata_o` and `bclk_o` are low. In master mode `ws_o` is high during reset, and the first frame starts at the fourth system clock after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_msbj_i | input | 1 | Framing select: 0 = I2S, 1 = MSB-justified |
| master_i | input | 1 | Role select: 0 = slave (clocks received), 1 = master (clocks driven) |
| sample_valid_i | input | 1 | One-cycle strobe that captures `left_i` and `right_i` as the pending pair |
| left_i | input | SAMPLE_W | Left-channel sample |
| right_i | input | SAMPLE_W | Right-channel sample |
| bclk_i | input | 1 | Bit clock from the link master (slave mode) |
| ws_i | input | 1 | Word select from the link master (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode, otherwise low) |
| ws_o | output | 1 | Generated word select (master mode, otherwise low) |
| sdata_o | output | 1 | Serial data |

## Verification
The bench builds the block with 24-bit samples, 32 slots per channel and a divide-by-4 bit clock, which are the defaults. It lowers `MUTE_FRAMES` from 12288 to 2, so the switch from muted frames to live frames falls inside a short run in all four role and framing combinations. With this setting, the repeated-pair case and the mid-frame write case both land on unmuted frames, and the full-scale, alternating and random words can be compared bit by bit against frames that the bench builds itself.

// File: rtl/ats_pkg.sv
// Shared encodings for the stereo serial audio transmitter.
// Assumes: framing and role selects are static outside of reset.
package ats_pkg;
    typedef enum logic {
        FMT_I2S  = 1'b0,
        FMT_MSBJ = 1'b1
    } ats_fmt_e;

    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } ats_role_e;
endpackage

// File: rtl/ats_clk_div.sv
// Master bit-clock generator: divides the system clock by DIV.
// Emits a one-cycle tick on the cycle whose edge makes the bit clock fall.
// Assumes: DIV is even and at least 2.
module ats_clk_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic bclk_o,
    output logic tick_o
);
    localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);
    localparam logic [DW-1:0] HALF = DW'(DIV / 2);

    logic [DW-1:0] cnt_q;

    // Free-running divider phase, parked at zero when not the link master.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign bclk_o = en_i && (cnt_q >= HALF);
    assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/ats_slave_sync.sv
// Brings received bit clock and word select into the system clock domain
// and flags each falling bit-clock edge.
// Assumes: the system clock is fast enough that each bit-clock phase lasts
// more than STAGES+1 system clocks.
module ats_slave_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic bclk_i,
    input  logic ws_i,
    output logic fall_o,
    output logic ws_o
);
    logic [STAGES-1:0] b_sync_q;
    logic [STAGES-1:0] w_sync_q;
    logic              b_prev_q;

    // Synchroniser chains for both received clocks plus an edge-history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_sync_q <= '0;
            w_sync_q <= '0;
            b_prev_q <= 1'b0;
        end else begin
            b_sync_q <= {b_sync_q[STAGES-2:0], bclk_i};
            w_sync_q <= {w_sync_q[STAGES-2:0], ws_i};
            b_prev_q <= b_sync_q[STAGES-1];
        end
    end

    assign fall_o = en_i && b_prev_q && !b_sync_q[STAGES-1];
    assign ws_o   = w_sync_q[STAGES-1];
endmodule

// File: rtl/ats_mute.sv
// Post-reset mute window: allows data only from frame MUTE_FRAMES+1 onward.
// allow_o is combinational so that it applies to the first bit of a frame.
// Assumes: frame_start_i pulses once per frame.
module ats_mute #(
    parameter int MUTE_FRAMES = 12288
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start_i,
    output logic allow_o
);
    localparam int CW = $clog2(MUTE_FRAMES + 2);
    localparam logic [CW-1:0] LIM = CW'(MUTE_FRAMES);

    logic [CW-1:0] cnt_q;
    logic          open_q;

    // Count muted frame starts; open permanently once the window is used up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            open_q <= 1'b0;
        end else if (frame_start_i && !open_q) begin
            if (cnt_q == LIM) begin
                open_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign allow_o = open_q || (frame_start_i && (cnt_q == LIM));
endmodule

// File: rtl/ats_serializer.sv
// Slot tracker and shifter shared by both framings and both roles.
// The slot register holds {channel, position}. The MSB is the channel
// (0 = left) and doubles as the master word select.
// Assumes: SLOTS is a power of two, and SAMPLE_W < SLOTS.
module ats_serializer #(
    parameter int SAMPLE_W = 24,
    parameter int SLOTS    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                master_i,
    input  logic                fmt_msbj_i,
    input  logic                ws_s_i,
    input  logic                sample_valid_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    input  logic                allow_i,
    output logic                frame_start_o,
    output logic                chan_o,
    output logic                sdata_o
);
    import ats_pkg::*;

    localparam int SLOT_W = $clog2(SLOTS);
    localparam int IDX_W  = $clog2(SAMPLE_W);

    logic [SLOT_W:0]     slot_q, slot_d;
    logic [SAMPLE_W-1:0] pend_l_q, pend_r_q, act_l_q, act_r_q;
    logic [SAMPLE_W-1:0] word;
    logic                hit, bit_d;
    int                  pos, idx;

    // Next slot: master counts freely; slave restarts on word-select change.
    always_comb begin
        if (master_i == ROLE_MASTER) begin
            slot_d = slot_q + 1'b1;
        end else if (ws_s_i != slot_q[SLOT_W]) begin
            slot_d = {ws_s_i, {SLOT_W{1'b0}}};
        end else if (&slot_q[SLOT_W-1:0]) begin
            slot_d = slot_q;
        end else begin
            slot_d = slot_q + 1'b1;
        end
    end

    assign frame_start_o = tick_i && (slot_d == '0);
    assign chan_o        = slot_q[SLOT_W];

    // Bit for the coming slot, taking the pending pair at a frame start.
    always_comb begin
        if (slot_d[SLOT_W]) begin
            word = frame_start_o ? pend_r_q : act_r_q;
        end else begin
            word = frame_start_o ? pend_l_q : act_l_q;
        end
        pos = int'(slot_d[SLOT_W-1:0]);
        if (fmt_msbj_i == FMT_MSBJ) begin
            hit = pos < SAMPLE_W;
            idx = SAMPLE_W - 1 - pos;
        end else begin
            hit = (pos >= 1) && (pos <= SAMPLE_W);
            idx = SAMPLE_W - pos;
        end
        bit_d = hit && word[idx[IDX_W-1:0]];
    end

    // Pending pair capture from the parallel side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_l_q <= '0;
            pend_r_q <= '0;
        end else if (sample_valid_i) begin
            pend_l_q <= left_i;
            pend_r_q <= right_i;
        end
    end

    // Slot advance, frame latch and data update on each falling bit clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q  <= '1;
            act_l_q <= '0;
            act_r_q <= '0;
            sdata_o <= 1'b0;
        end else if (tick_i) begin
            slot_q  <= slot_d;
            sdata_o <= allow_i && bit_d;
            if (frame_start_o) begin
                act_l_q <= pend_l_q;
                act_r_q <= pend_r_q;
            end
        end
    end
endmodule

// File: rtl/ats_tx.sv
// Stereo serial audio transmitter top: selects the bit-clock source for the
// role, runs the shared shifter and applies the post-reset mute window.
// Assumes: master_i and fmt_msbj_i change only while reset is held.
module ats_tx #(
    parameter int SAMPLE_W    = 24,
    parameter int SLOTS       = 32,
    parameter int MCLK_DIV    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int MUTE_FRAMES = 12288
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fmt_msbj_i,
    input  logic                master_i,
    input  logic                sample_valid_i,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    input  logic                bclk_i,
    input  logic                ws_i,
    output logic                bclk_o,
    output logic                ws_o,
    output logic                sdata_o
);
    logic m_bclk, m_tick, s_fall, s_ws, tick, frame_start, allow, chan;

    ats_clk_div #(.DIV(MCLK_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (master_i),
        .bclk_o (m_bclk),
        .tick_o (m_tick)
    );

    ats_slave_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (!master_i),
        .bclk_i (bclk_i),
        .ws_i   (ws_i),
        .fall_o (s_fall),
        .ws_o   (s_ws)
    );

    assign tick = master_i ? m_tick : s_fall;

    ats_serializer #(.SAMPLE_W(SAMPLE_W), .SLOTS(SLOTS)) u_ser (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_i         (tick),
        .master_i       (master_i),
        .fmt_msbj_i     (fmt_msbj_i),
        .ws_s_i         (s_ws),
        .sample_valid_i (sample_valid_i),
        .left_i         (left_i),
        .right_i        (right_i),
        .allow_i        (allow),
        .frame_start_o  (frame_start),
        .chan_o         (chan),
        .sdata_o        (sdata_o)
    );

    ats_mute #(.MUTE_FRAMES(MUTE_FRAMES)) u_mute (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start),
        .allow_o       (allow)
    );

    assign bclk_o = master_i && m_bclk;
    assign ws_o   = master_i && chan;
endmodule

// File: rtl/ats_tx_chk.sv
// Port-level checker for ats_tx in master mode. It tracks frame starts
// itself in order to check the mute window.
module ats_tx_chk #(
    parameter int MUTE_FRAMES = 12288
) (
    input logic clk,
    input logic rst_n,
    input logic master_i,
    input logic bclk_o,
    input logic ws_o,
    input logic sdata_o
);
    localparam int CW = $clog2(MUTE_FRAMES + 3);
    localparam logic [CW-1:0] LIM = CW'(MUTE_FRAMES);
    localparam logic [CW-1:0] SAT = CW'(MUTE_FRAMES + 1);

    logic          ws_prev_q;
    logic [CW-1:0] seen_q;
    logic          ws_fell;

    assign ws_fell = master_i && ws_prev_q && !ws_o;

    // Frame starts observed on the word-select port, saturating past the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_prev_q <= 1'b1;
            seen_q    <= '0;
        end else begin
            ws_prev_q <= ws_o;
            if (ws_fell && seen_q != SAT) begin
                seen_q <= seen_q + 1'b1;
            end
        end
    end

    a_r1_bclk_high_hold: assert property (@(posedge clk) disable iff (!rst_n)
        master_i && $rose(bclk_o) |=> bclk_o);

    a_r1_bclk_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
        master_i && $fell(bclk_o) |=> !bclk_o);

    a_r2_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        master_i && !$stable(ws_o) |-> $fell(bclk_o));

    a_r6_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        master_i && !$stable(sdata_o) |-> $fell(bclk_o));

    a_r9_mute_hold: assert property (@(posedge clk) disable iff (!rst_n)
        master_i && ((ws_fell && seen_q < LIM) || (!ws_fell && seen_q <= LIM))
        |-> !sdata_o);
endmodule

bind ats_tx ats_tx_chk #(.MUTE_FRAMES(MUTE_FRAMES)) u_ats_tx_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .master_i (master_i),
    .bclk_o   (bclk_o),
    .ws_o     (ws_o),
    .sdata_o  (sdata_o)
);

// File: tb/test_ats_tx.sv
module test_ats_tx;
    localparam int W    = 24;
    localparam int MUTE = 2;
    localparam int NFR  = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fmt_msbj_i = 1'b0;
    logic         master_i = 1'b1;
    logic         sample_valid_i = 1'b0;
    logic [W-1:0] left_i = '0;
    logic [W-1:0] right_i = '0;
    logic         bclk_i = 1'b1;
    logic         ws_i = 1'b1;
    logic         bclk_o, ws_o, sdata_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic pb = 1'b0;
    logic held_d = 1'b0;
    bit   r6_bad = 1'b0;

    always #2 clk = ~clk;

    ats_tx #(.SAMPLE_W(W), .MUTE_FRAMES(MUTE)) i_ats_tx (
        .clk(clk), .rst_n(rst_n), .fmt_msbj_i(fmt_msbj_i), .master_i(master_i),
        .sample_valid_i(sample_valid_i), .left_i(left_i), .right_i(right_i),
        .bclk_i(bclk_i), .ws_i(ws_i), .bclk_o(bclk_o), .ws_o(ws_o), .sdata_o(sdata_o)
    );

    // Expected 64-slot frame, slot s at bit s, built from R4/R5.
    function automatic logic [63:0] exp_frame(logic [W-1:0] l, logic [W-1:0] r, logic msbj);
        logic [63:0] v = '0;
        for (int s = 0; s < 64; s++) begin
            int p = s % 32;
            logic [W-1:0] wd = (s >= 32) ? r : l;
            if (msbj) begin
                if (p < W) v[s] = wd[W-1-p];
            end else begin
                if (p >= 1 && p <= W) v[s] = wd[W-p];
            end
        end
        return v;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(logic [W-1:0] l, logic [W-1:0] r);
        sample_valid_i = 1'b1;
        left_i = l;
        right_i = r;
        @(negedge clk);
        sample_valid_i = 1'b0;
    endtask

    // Wait for the next observed rise of bclk_o; report spacing in system clocks.
    task automatic next_rise(output logic w, output logic d, output int sp);
        logic cur;
        sp = 0;
        forever begin
            @(negedge clk);
            sp++;
            cur = bclk_o;
            if (cur && pb && sdata_o !== held_d) r6_bad = 1'b1;
            if (cur && !pb) begin
                pb = cur;
                w = ws_o;
                d = sdata_o;
                held_d = d;
                return;
            end
            pb = cur;
        end
    endtask

    task automatic pick_words(int fr, output logic [W-1:0] l, output logic [W-1:0] r);
        if (fr == 1) begin
            l = 24'h800001; r = 24'h7FFFFE;
        end else if (fr == 2) begin
            l = 24'hFFFFFF; r = 24'h000000;
        end else if (fr == 4) begin
            l = 24'hAAAAAA; r = 24'h555555;
        end else begin
            l = W'($urandom); r = W'($urandom);
        end
    endtask

    task automatic run_phase(logic m, logic f);
        logic [W-1:0] nxt_l, nxt_r, new_l, new_r, exp_l, exp_r;
        logic [63:0] gd, gw, ex;
        logic w, d;
        int sp;
        bit sp_bad, quiet_bad, ld;
        rst_n = 1'b0; master_i = m; fmt_msbj_i = f;
        sample_valid_i = 1'b0; bclk_i = 1'b1; ws_i = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10 reset outputs", {61'b0, bclk_o, ws_o, sdata_o}, {61'b0, 1'b0, m, 1'b0});
        rst_n = 1'b1;
        pb = 1'b0;
        load(24'h123456, 24'hFEDCBA);
        nxt_l = 24'h123456; nxt_r = 24'hFEDCBA;
        if (m) begin
            next_rise(w, d, sp);
            chk("R10 first rise is right slot", {63'b0, w}, 64'd1);
        end else begin
            repeat (10) @(negedge clk);
        end
        for (int fr = 1; fr <= NFR; fr++) begin
            exp_l = nxt_l; exp_r = nxt_r;
            ld = (fr != 3) && (fr != 5);
            pick_words(fr, new_l, new_r);
            gd = '0; gw = '0; sp_bad = 1'b0; quiet_bad = 1'b0; r6_bad = 1'b0;
            for (int s = 0; s < 64; s++) begin
                if (m) begin
                    next_rise(w, d, sp);
                    gd[s] = d; gw[s] = w;
                    if (sp != 4 && !(s == 41 && ld)) sp_bad = 1'b1;
                    if (s == 41 && ld && sp != 3) sp_bad = 1'b1;
                    if (s == 40 && ld) begin
                        load(new_l, new_r);
                        pb = bclk_o;
                    end
                end else begin
                    bclk_i = 1'b0; ws_i = (s >= 32);
                    repeat (8) @(negedge clk);
                    gd[s] = sdata_o;
                    if (bclk_o || ws_o) quiet_bad = 1'b1;
                    bclk_i = 1'b1;
                    if (s == 40 && ld) begin
                        load(new_l, new_r);
                        repeat (7) @(negedge clk);
                    end else begin
                        repeat (8) @(negedge clk);
                    end
                end
            end
            ex = (fr <= MUTE) ? 64'd0 : exp_frame(exp_l, exp_r, f);
            if (f) chk("R5 frame data (R7/R8/R9)", gd, ex);
            else   chk("R4 frame data (R7/R8/R9)", gd, ex);
            if (m) begin
                chk("R2 word select per slot", gw, 64'hFFFFFFFF_00000000);
                chk("R1 bit clock spacing", {63'b0, sp_bad}, 64'd0);
                chk("R6 data stable while bit clock high", {63'b0, r6_bad}, 64'd0);
            end else begin
                chk("R3 clock outputs quiet in slave", {63'b0, quiet_bad}, 64'd0);
            end
            if (ld) begin
                nxt_l = new_l; nxt_r = new_r;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20231));
        run_phase(1'b1, 1'b0);
        run_phase(1'b1, 1'b1);
        run_phase(1'b0, 1'b0);
        run_phase(1'b0, 1'b1);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual no completion, expected end of run");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule